// File: doc/BRIEF.md
# Dual-Channel Quadrature Phase Oscillator

This block produces the quadrature mixing phase for two independent receive channels. Each channel has a 24-bit phase accumulator. The accumulator advances by a programmable tuning step once per accepted sample tick. The upper phase bits address a quarter-wave sine table, and the block returns a signed cosine and sine pair for each channel. A mixer downstream multiplies these values with the incoming samples.

The tuning step for a wanted frequency f is int(f / fs × 2^24), where fs = 18.432 MHz is the sample rate. A host writes each step as two 12-bit halves through a plain configuration port. The low half is first held in a per-channel shadow register. Writing the high half commits both halves in a single cycle, so the channel never runs with a step made of one old half and one new half.

Sample ticks enter on a valid/ready stream, and results leave on a valid/ready stream. A tick is accepted when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While the consumer holds `m_ready` low with `m_valid` high, the result stays frozen and no further ticks are accepted.

Top module: `dual_dco`

## Requirements
- R1: A synchronous reset clears both accumulators, both active steps, both shadow halves and `m_valid`. It also drives `m_cos` and `m_sin` to zero, and afterwards `s_ready` is 1.
- R2: A write with `cfg_we`=1 and `cfg_hi`=0 stores `cfg_data` in the shadow low half of channel `cfg_ch` only. The step that channel uses is unchanged until a later high write.
- R3: A write with `cfg_we`=1 and `cfg_hi`=1 sets the active step of channel `cfg_ch` to {`cfg_data`, shadow low half} in one cycle. The new step is first added on a tick accepted in a later cycle.
- R4: On each accepted tick, every channel's accumulator becomes (phase + active step) mod 2^24.
- R5: The two channels are independent. A write addressed to one channel never alters the step, shadow or output sequence of the other channel.
- R6: On an accepted tick, channel c's sine output (`m_sin[c*12 +: 12]`, two's complement) is loaded from the phase held before the step. With k = phase[23:14], quadrant = k[9:8] and q = k[7:0], define Q(i) = floor(2047·sin(π/2·(i+0.5)/256) + 0.5). The output is Q(q), Q(255−q), −Q(q) or −Q(255−q) for quadrant 0, 1, 2 or 3 respectively.
- R7: Channel c's cosine output (`m_cos[c*12 +: 12]`) is the R6 sine value at index (k + 256) mod 1024.
- R8: `s_ready` = !`m_valid` | `m_ready`. When `m_valid` is 1 and `m_ready` is 0, the outputs and `m_valid` hold and no accumulator moves. Without an accepted tick, `m_valid` falls after a cycle in which `m_ready` was 1.
- R9: The step for a 4.5 MHz tone, int(4.5/18.432 × 2^24) = 0x3E8000, written as low 0x000 and then high 0x3E8, produces the R6/R7 outputs for phases n·0x3E8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_hi | input | 1 | 1 selects the high half (commit), 0 selects the low half (shadow) |
| cfg_data | input | 12 | Half of the tuning step |
| s_valid | input | 1 | Sample tick offered |
| s_ready | output | 1 | Tick can be accepted this cycle |
| m_valid | output | 1 | Output pair present |
| m_ready | input | 1 | Consumer takes the output pair |
| m_cos | output | 24 | Signed cosine, channel c at bits [c*12 +: 12] |
| m_sin | output | 24 | Signed sine, channel c at bits [c*12 +: 12] |

## Verification
Several properties are checked by assertions on every cycle: that reset clears state, that a low write leaves the active step untouched, that a high write commits both halves together, that each accepted tick adds exactly one step, and that a stalled output and accumulator stay frozen. The numerical content cannot be shown that way. The table values, the quadrant folding, the quarter-turn offset of the cosine, and the absence of cross-talk between channels are shown only by the bench scenarios. The bench compares each output pair against a table rebuilt from the formula while directed and random writes and random stalls are applied.

// File: rtl/dco_pkg.sv
package dco_pkg;
  localparam real PI = 3.14159265358979323846;

  // Quarter-wave magnitude at the centre of bin idx out of 2**qbits bins
  function automatic int quarter_mag(input int idx, input int qbits, input int amp);
    real ang;
    ang = PI * (real'(idx) + 0.5) / (2.0 * real'(1 << qbits));
    return $rtoi($floor(real'(amp) * $sin(ang) + 0.5));
  endfunction
endpackage

// File: rtl/dco_incr_regs.sv
module dco_incr_regs #(
  parameter int HALF_W = 12,
  localparam int STEP_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              hi,
  input  logic [HALF_W-1:0] data,
  output logic [STEP_W-1:0] step
);
  logic [HALF_W-1:0] shadow_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_lo <= '0;
      step      <= '0;
    end else if (we) begin
      if (hi) step      <= {data, shadow_lo};
      else    shadow_lo <= data;
    end
  end

  // R2: a low write leaves the active step untouched
  a_r2_lo_quiet: assert property (@(posedge clk) disable iff (rst)
    (we && !hi) |=> $stable(step));
  // R3: a high write commits both halves together
  a_r3_commit: assert property (@(posedge clk) disable iff (rst)
    (we && hi) |=> (step[STEP_W-1:HALF_W] == $past(data)) && (step[HALF_W-1:0] == $past(shadow_lo)));
endmodule

// File: rtl/dco_phase_acc.sv
module dco_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= phase + step;
  end

  // R1: reset clears the accumulator
  a_r1_acc_clear: assert property (@(posedge clk) rst |=> (phase == '0));
  // R4: one step per accepted tick, wrapping
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    adv |=> (phase == ACC_W'($past(phase) + $past(step))));
  // R8: no movement without a tick
  a_r8_no_step: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(phase));
endmodule

// File: rtl/dco_sincos_lut.sv
module dco_sincos_lut #(
  parameter int IDX_W = 10,
  parameter int OUT_W = 12,
  parameter int AMP   = 2047,
  localparam int QB     = IDX_W - 2,
  localparam int QDEPTH = 1 << QB
) (
  input  logic [IDX_W-1:0]        idx,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);
  logic [OUT_W-1:0] rom [QDEPTH];

  for (genvar i = 0; i < QDEPTH; i++) begin : g_rom
    assign rom[i] = OUT_W'(dco_pkg::quarter_mag(i, QB, AMP));
  end

  logic [IDX_W-1:0] idx_c;
  assign idx_c = idx + IDX_W'(QDEPTH);

  function automatic logic [OUT_W-1:0] fold(input logic [IDX_W-1:0] k,
                                            input logic [OUT_W-1:0] tab [QDEPTH]);
    logic [QB-1:0]    q;
    logic [OUT_W-1:0] mag;
    q   = k[QB] ? ~k[QB-1:0] : k[QB-1:0];
    mag = tab[q];
    return k[IDX_W-1] ? (~mag + 1'b1) : mag;
  endfunction

  always_comb begin
    sin_o = fold(idx, rom);
    cos_o = fold(idx_c, rom);
  end
endmodule

// File: rtl/dual_dco.sv
module dual_dco #(
  parameter int NUM_CH  = 2,
  parameter int HALF_W  = 12,
  parameter int IDX_W   = 10,
  parameter int OUT_W   = 12,
  parameter int AMP     = 2047,
  localparam int ACC_W  = 2 * HALF_W,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [CH_W-1:0]         cfg_ch,
  input  logic                    cfg_hi,
  input  logic [HALF_W-1:0]       cfg_data,
  input  logic                    s_valid,
  output logic                    s_ready,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [NUM_CH*OUT_W-1:0] m_cos,
  output logic [NUM_CH*OUT_W-1:0] m_sin
);
  logic accept;
  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst)         m_valid <= 1'b0;
    else if (accept) m_valid <= 1'b1;
    else if (m_ready) m_valid <= 1'b0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ACC_W-1:0]        step;
    logic [ACC_W-1:0]        phase;
    logic signed [OUT_W-1:0] cos_w, sin_w;
    logic                    sel;

    assign sel = cfg_we && (cfg_ch == CH_W'(c));

    dco_incr_regs #(.HALF_W(HALF_W)) u_regs (
      .clk(clk), .rst(rst), .we(sel), .hi(cfg_hi), .data(cfg_data), .step(step));

    dco_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .adv(accept), .step(step), .phase(phase));

    dco_sincos_lut #(.IDX_W(IDX_W), .OUT_W(OUT_W), .AMP(AMP)) u_lut (
      .idx(phase[ACC_W-1 -: IDX_W]), .cos_o(cos_w), .sin_o(sin_w));

    always_ff @(posedge clk) begin
      if (rst) begin
        m_cos[c*OUT_W +: OUT_W] <= '0;
        m_sin[c*OUT_W +: OUT_W] <= '0;
      end else if (accept) begin
        m_cos[c*OUT_W +: OUT_W] <= cos_w;
        m_sin[c*OUT_W +: OUT_W] <= sin_w;
      end
    end
  end

  // R1: reset empties the output stage
  a_r1_out_clear: assert property (@(posedge clk) rst |=> (!m_valid && m_cos == '0 && m_sin == '0));
  // R8: a stalled result holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_cos) && $stable(m_sin)));
endmodule

// File: tb/dual_dco_test.sv
module dual_dco_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_ch = '0;
  logic        cfg_hi = 1'b0;
  logic [11:0] cfg_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [23:0] m_cos, m_sin;

  always #10 clk = ~clk;

  dual_dco uut (.*);

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // Model state
  logic [11:0] sh [2];
  logic [23:0] act [2];
  logic [23:0] ph [2];
  logic [11:0] ecos [2];
  logic [11:0] esin [2];
  logic        ev;

  function automatic int qmag(input int i);
    real a;
    a = 3.14159265358979323846 * (real'(i) + 0.5) / 512.0;
    return $rtoi($floor(2047.0 * $sin(a) + 0.5));
  endfunction

  function automatic logic [11:0] exp_sin(input logic [9:0] k);
    int q, m;
    q = k[8] ? 255 - int'(k[7:0]) : int'(k[7:0]);
    m = qmag(q);
    return k[9] ? 12'(-m) : 12'(m);
  endfunction

  function automatic logic [11:0] exp_cos(input logic [9:0] k);
    return exp_sin(k + 10'd256);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      sh[c] = '0; act[c] = '0; ph[c] = '0; ecos[c] = '0; esin[c] = '0;
    end
    ev = 1'b0;
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input logic we, input logic ch, input logic hi,
                      input logic [11:0] d, input logic sv, input logic mr);
    logic accept;
    cfg_we = we; cfg_ch = ch; cfg_hi = hi; cfg_data = d; s_valid = sv; m_ready = mr;
    #1;
    chk({tag, "/R8 s_ready"}, 32'(s_ready), 32'(!ev || mr));
    @(posedge clk);
    accept = sv && (!ev || mr);
    if (accept) begin
      for (int c = 0; c < 2; c++) begin
        ecos[c] = exp_cos(ph[c][23:14]);
        esin[c] = exp_sin(ph[c][23:14]);
        ph[c]   = ph[c] + act[c];
      end
      ev = 1'b1;
    end else if (mr) ev = 1'b0;
    if (we) begin
      if (hi) act[ch] = {d, sh[ch]};
      else    sh[ch]  = d;
    end
    @(negedge clk);
    chk({tag, "/R8 m_valid"}, 32'(m_valid), 32'(ev));
    if (ev) begin
      for (int c = 0; c < 2; c++) begin
        chk({tag, "/R6 sin"}, 32'(m_sin[c*12 +: 12]), 32'(esin[c]));
        chk({tag, "/R7 cos"}, 32'(m_cos[c*12 +: 12]), 32'(ecos[c]));
      end
    end
  endtask

  task automatic idle_ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 1'b0, 12'h0, 1'b1, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    int incr_45;
    seed_dummy = $urandom(32'd1234);
    model_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 m_valid", 32'(m_valid), 32'd0);
    chk("R1 m_cos", 32'(m_cos), 32'd0);
    chk("R1 m_sin", 32'(m_sin), 32'd0);
    chk("R1 s_ready", 32'(s_ready), 32'd1);
    idle_ticks("R1", 3);

    // R9 formula-derived step on channel 0
    incr_45 = $rtoi(4.5 / 18.432 * 16777216.0);
    chk("R9 formula", 32'(incr_45), 32'h3E8000);
    step("R9", 1'b1, 1'b0, 1'b0, 12'(incr_45), 1'b0, 1'b1);
    step("R9", 1'b1, 1'b0, 1'b1, 12'(incr_45 >> 12), 1'b0, 1'b1);
    idle_ticks("R9", 12);

    // R2 low half alone must not retune
    step("R2", 1'b1, 1'b0, 1'b0, 12'hABC, 1'b1, 1'b1);
    idle_ticks("R2", 10);
    // R3 commit with the high half, tick in the same cycle uses the old step
    step("R3", 1'b1, 1'b0, 1'b1, 12'h123, 1'b1, 1'b1);
    idle_ticks("R3", 10);
    // R4 wrap: near-full step on channel 0
    step("R4", 1'b1, 1'b0, 1'b0, 12'hFFF, 1'b0, 1'b1);
    step("R4", 1'b1, 1'b0, 1'b1, 12'hFFF, 1'b0, 1'b1);
    idle_ticks("R4", 8);
    // R5 channel 1 writes only
    step("R5", 1'b1, 1'b1, 1'b0, 12'h555, 1'b1, 1'b1);
    step("R5", 1'b1, 1'b1, 1'b1, 12'h0F0, 1'b1, 1'b1);
    idle_ticks("R5", 10);
    // R8 long stall then drain
    step("R8", 1'b0, 1'b0, 1'b0, 12'h0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step("R8", 1'b0, 1'b0, 1'b0, 12'h0, 1'b1, 1'b0);
    step("R8", 1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 1'b1);
    step("R8", 1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 1'b0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic we, ch, hi, sv, mr;
      logic [11:0] d;
      we = ($urandom % 8) == 0;
      ch = 1'($urandom);
      hi = 1'($urandom);
      d  = 12'($urandom);
      sv = ($urandom % 4) != 0;
      mr = ($urandom % 3) != 0;
      step("R4 rand", we, ch, hi, d, sv, mr);
    end

    // R1 reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1 re-reset m_valid", 32'(m_valid), 32'd0);
    chk("R1 re-reset m_sin", 32'(m_sin), 32'd0);
    idle_ticks("R1", 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule